// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block is the device-side front end of a NAND flash memory. It watches the shared 8-bit bus on every write strobe, which marks a rising edge of the host's write enable, and sorts each byte by the two latch qualifiers. With the command qualifier high the byte is an opcode. With the address qualifier high it is an address byte. With both low it is program data. The block checks two-step command sequences and builds the column and row addresses from the address bytes. It refuses commands that the busy state or write protection forbid. It then issues single-cycle start pulses to the array, timing and ECC logic that sit behind it. That logic is outside this block, and the bench replaces it with a busy input.

The block also keeps the column counter. A read strobe, which marks a falling edge of the host's read enable, advances it during data output. Each accepted program data byte advances it as well. The counter can be moved inside the open page during output and during program data entry. An output selector tells the output path what to drive: page data, status, ID bytes or ECC status.

Top module: `nseq_front`

## Requirements
- R1: On reset the column and row are zero, the output selector is data (0), and no pulse is raised. The command register then acts as if 00h had been received, so four address bytes followed by 30h give `go_read`.
- R2: In a full address the bytes map as follows. Byte 1 is column[7:0]. The low four bits of byte 2 are column[11:8], and its upper four bits are ignored. Byte 3 is row[7:0] and byte 4 is row[15:8]. The read confirm 30h copies both into `col_addr`/`row_addr` in the same cycle as `go_read`.
- R3: A fifth address byte after a full address is accepted but changes neither the column nor the row.
- R4: 80h, four address bytes, data bytes and then 10h give `go_prog` if write protect is not active. Each data byte pulses `din_wr` with the current column in `din_col` and then advances the column by one.
- R5: During program data entry, 85h followed by two column bytes moves the column. Later data bytes are written from the new column.
- R6: 60h, two row bytes (row[7:0], then row[15:8]) and D0h give `go_erase` with the new row. The column is left unchanged.
- R7: While `wp_n` is low, neither 10h nor D0h raises any program or erase pulse.
- R8: While `busy` is high, only 70h (status) and FFh (reset) take effect. All other commands, address bytes, data bytes and read strobes are ignored.
- R9: After 80h, any valid command other than 85h, 10h or FFh ends the program. That command runs in its own mode, and a later 10h raises no pulse.
- R10: In data output mode a read strobe advances the column by one. In status mode it leaves the column unchanged.
- R11: 70h pulses `go_status` and selects status output (1). A following 00h selects data output (0) again and keeps the column, with no new address needed.
- R12: 05h, two column bytes and E0h move the output column. 00h, a full address and 35h pulse `go_cbread`. A following 85h, a full address, optional data and 10h pulse `go_cbprog`.
- R13: 90h followed by one address byte pulses `go_id` and selects ID output (2). 7Ah pulses `go_ecc` and selects ECC output (3). FFh pulses `go_reset`.
- R14: An opcode outside the command set is discarded and leaves every state unchanged. For example, a program that is open still completes on 10h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle mark of a write-enable rising edge |
| rd_stb | input | 1 | One-cycle mark of a read-enable falling edge |
| cle | input | 1 | Command qualifier |
| ale | input | 1 | Address qualifier |
| io_in | input | DW | Bus byte |
| wp_n | input | 1 | Write protect, active low |
| busy | input | 1 | Array operation in progress |
| go_read | output | 1 | Page read start pulse |
| go_cbread | output | 1 | Copy-back read start pulse |
| go_prog | output | 1 | Page program start pulse |
| go_cbprog | output | 1 | Copy-back program start pulse |
| go_erase | output | 1 | Block erase start pulse |
| go_id | output | 1 | ID output start pulse |
| go_status | output | 1 | Status read pulse |
| go_ecc | output | 1 | ECC status read pulse |
| go_reset | output | 1 | Reset pulse |
| din_wr | output | 1 | Program data byte write pulse |
| din_col | output | COL_W | Column of the written byte |
| din_byte | output | DW | Written byte |
| col_addr | output | COL_W | Current column |
| row_addr | output | ROW_W | Current row |
| out_sel | output | 2 | Output source: 0 data, 1 status, 2 ID, 3 ECC |

## Verification
The command grammar is tried with complete sequences of each kind: read, program, erase, copy-back, column change, ID, ECC and reset. It is also tried with broken sequences: a fifth address byte, a foreign opcode inside a program, a valid opcode that ends a program, and commands given while busy or while write protect is active. Complete sequences confirm the address byte mapping and the pulse chosen for each kind. Broken sequences separate a design that only counts opcodes from one that tracks which step of the grammar it is in. Read strobes given in data, status and busy states separate column advance from column hold.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  typedef enum logic [3:0] {
    OP_BAD, OP_RD1, OP_RD2, OP_CB2, OP_CO1, OP_CO2, OP_PG1, OP_PG2,
    OP_X85, OP_ER1, OP_ER2, OP_ID, OP_ST, OP_ECC, OP_RST
  } op_e;

  typedef enum logic [1:0] {OS_DATA, OS_STATUS, OS_ID, OS_ECC} osel_e;

  typedef enum logic [2:0] {
    PD_NONE, PD_FULL_RD, PD_FULL_PG, PD_COL_OUT, PD_COL_IN, PD_ROW_ER, PD_ID
  } pend_e;
endpackage

// File: rtl/nseq_op_decode.sv
module nseq_op_decode
  import nseq_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op
);
  always_comb begin
    case (code)
      8'h00: op = OP_RD1;
      8'h30: op = OP_RD2;
      8'h35: op = OP_CB2;
      8'h05: op = OP_CO1;
      8'hE0: op = OP_CO2;
      8'h80: op = OP_PG1;
      8'h10: op = OP_PG2;
      8'h85: op = OP_X85;
      8'h60: op = OP_ER1;
      8'hD0: op = OP_ER2;
      8'h90: op = OP_ID;
      8'h70: op = OP_ST;
      8'h7A: op = OP_ECC;
      8'hFF: op = OP_RST;
      default: op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/nseq_addr_stage.sv
module nseq_addr_stage
  import nseq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int COL_W = 12,
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ab_we,
  input  pend_e            pend,
  input  logic [DW-1:0]    ab,
  output logic [COL_W-1:0] col_stage,
  output logic [ROW_W-1:0] row_stage,
  output logic [2:0]       ab_cnt
);
  localparam int CHI = COL_W - DW;
  localparam int RHI = ROW_W - DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_stage <= '0;
      row_stage <= '0;
      ab_cnt    <= '0;
    end else if (clr) begin
      ab_cnt <= '0;
    end else if (ab_we) begin
      if (ab_cnt != 3'd7) ab_cnt <= ab_cnt + 3'd1;
      case (pend)
        PD_FULL_RD, PD_FULL_PG: begin
          case (ab_cnt)
            3'd0: col_stage[DW-1:0]     <= ab;
            3'd1: col_stage[COL_W-1:DW] <= ab[CHI-1:0];
            3'd2: row_stage[DW-1:0]     <= ab;
            3'd3: row_stage[ROW_W-1:DW] <= ab[RHI-1:0];
            default: ;
          endcase
        end
        PD_COL_OUT, PD_COL_IN: begin
          if (ab_cnt == 3'd0) col_stage[DW-1:0] <= ab;
          else if (ab_cnt == 3'd1) col_stage[COL_W-1:DW] <= ab[CHI-1:0];
        end
        PD_ROW_ER: begin
          if (ab_cnt == 3'd0) row_stage[DW-1:0] <= ab;
          else if (ab_cnt == 3'd1) row_stage[ROW_W-1:DW] <= ab[RHI-1:0];
        end
        default: ;
      endcase
    end
  end

  // R3: bytes beyond the fourth of a full address leave the staged address alone
  a_r3_extra_byte_ignored: assert property (@(posedge clk) disable iff (rst)
    $past(ab_we && !clr && ab_cnt >= 3'd4 && (pend == PD_FULL_RD || pend == PD_FULL_PG))
    |-> (col_stage == $past(col_stage) && row_stage == $past(row_stage)));
endmodule

// File: rtl/nseq_front.sv
module nseq_front
  import nseq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int COL_W = 12,
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic             cle,
  input  logic             ale,
  input  logic [DW-1:0]    io_in,
  input  logic             wp_n,
  input  logic             busy,
  output logic             go_read,
  output logic             go_cbread,
  output logic             go_prog,
  output logic             go_cbprog,
  output logic             go_erase,
  output logic             go_id,
  output logic             go_status,
  output logic             go_ecc,
  output logic             go_reset,
  output logic             din_wr,
  output logic [COL_W-1:0] din_col,
  output logic [DW-1:0]    din_byte,
  output logic [COL_W-1:0] col_addr,
  output logic [ROW_W-1:0] row_addr,
  output logic [1:0]       out_sel
);
  localparam int CHI = COL_W - DW;
  localparam int RHI = ROW_W - DW;

  op_e   op;
  pend_e pend;
  osel_e os_q;
  logic  prog_open, cb_prog, cb_ok;
  logic [COL_W-1:0] col_stage;
  logic [ROW_W-1:0] row_stage;
  logic [2:0]       ab_cnt;

  nseq_op_decode u_dec (.code(io_in[7:0]), .op(op));

  logic cmd_we, cmd_acc, adr_we, dat_we, stage_we, stage_clr;
  assign cmd_we  = wr_stb && cle && !ale;
  assign cmd_acc = cmd_we && (op != OP_BAD) && (!busy || op == OP_ST || op == OP_RST);
  assign adr_we  = wr_stb && ale && !cle && !busy;
  assign dat_we  = wr_stb && !ale && !cle && !busy && prog_open && pend == PD_NONE;
  assign stage_we = adr_we && (pend inside {PD_FULL_RD, PD_FULL_PG, PD_COL_OUT,
                                            PD_COL_IN, PD_ROW_ER});
  assign stage_clr = cmd_acc && ((op inside {OP_RD1, OP_CO1, OP_PG1, OP_ER1, OP_ID, OP_RST})
                     || (op == OP_X85 && (prog_open || cb_ok)));

  nseq_addr_stage #(.DW(DW), .COL_W(COL_W), .ROW_W(ROW_W)) u_stage (
    .clk(clk), .rst(rst), .clr(stage_clr), .ab_we(stage_we), .pend(pend),
    .ab(io_in), .col_stage(col_stage), .row_stage(row_stage), .ab_cnt(ab_cnt)
  );

  assign out_sel = os_q;

  always_ff @(posedge clk) begin
    go_read <= 1'b0; go_cbread <= 1'b0; go_prog <= 1'b0; go_cbprog <= 1'b0;
    go_erase <= 1'b0; go_id <= 1'b0; go_status <= 1'b0; go_ecc <= 1'b0;
    go_reset <= 1'b0; din_wr <= 1'b0;
    if (rst) begin
      pend <= PD_FULL_RD; os_q <= OS_DATA;
      prog_open <= 1'b0; cb_prog <= 1'b0; cb_ok <= 1'b0;
      col_addr <= '0; row_addr <= '0; din_col <= '0; din_byte <= '0;
    end else if (cmd_acc) begin
      if (op != OP_X85) prog_open <= 1'b0;
      case (op)
        OP_RST: begin
          go_reset <= 1'b1; pend <= PD_FULL_RD; os_q <= OS_DATA; cb_ok <= 1'b0;
        end
        OP_ST, OP_ECC: begin
          if (op == OP_ST) begin go_status <= 1'b1; os_q <= OS_STATUS; end
          else begin go_ecc <= 1'b1; os_q <= OS_ECC; end
          if (pend inside {PD_FULL_PG, PD_COL_IN}) pend <= PD_NONE;
        end
        OP_RD1: begin pend <= PD_FULL_RD; os_q <= OS_DATA; end
        OP_RD2, OP_CB2: begin
          if (pend == PD_FULL_RD && ab_cnt >= 3'd4) begin
            col_addr <= col_stage; row_addr <= row_stage;
            pend <= PD_NONE; os_q <= OS_DATA;
            if (op == OP_RD2) begin go_read <= 1'b1; cb_ok <= 1'b0; end
            else begin go_cbread <= 1'b1; cb_ok <= 1'b1; end
          end
        end
        OP_CO1: pend <= PD_COL_OUT;
        OP_CO2: begin
          if (pend == PD_COL_OUT && ab_cnt >= 3'd2) begin
            col_addr <= col_stage; pend <= PD_NONE; os_q <= OS_DATA;
          end
        end
        OP_PG1: begin pend <= PD_FULL_PG; cb_prog <= 1'b0; cb_ok <= 1'b0; end
        OP_X85: begin
          if (prog_open) pend <= PD_COL_IN;
          else if (cb_ok) begin pend <= PD_FULL_PG; cb_prog <= 1'b1; cb_ok <= 1'b0; end
        end
        OP_PG2: begin
          if (prog_open) begin
            pend <= PD_NONE;
            if (wp_n) begin
              if (cb_prog) go_cbprog <= 1'b1;
              else go_prog <= 1'b1;
            end
          end
        end
        OP_ER1: pend <= PD_ROW_ER;
        OP_ER2: begin
          if (pend == PD_ROW_ER && ab_cnt >= 3'd2) begin
            pend <= PD_NONE;
            if (wp_n) begin go_erase <= 1'b1; row_addr <= row_stage; end
          end
        end
        OP_ID: begin pend <= PD_ID; os_q <= OS_ID; end
        default: ;
      endcase
    end else if (adr_we) begin
      if (pend == PD_FULL_PG && ab_cnt == 3'd3) begin
        col_addr <= col_stage;
        row_addr <= {io_in[RHI-1:0], row_stage[DW-1:0]};
        prog_open <= 1'b1; pend <= PD_NONE;
      end else if (pend == PD_COL_IN && ab_cnt == 3'd1) begin
        col_addr <= {io_in[CHI-1:0], col_stage[DW-1:0]};
        pend <= PD_NONE;
      end else if (pend == PD_ID) begin
        go_id <= 1'b1; pend <= PD_NONE;
      end
    end else if (dat_we) begin
      din_wr <= 1'b1; din_col <= col_addr; din_byte <= io_in;
      col_addr <= col_addr + 1'b1;
    end else if (rd_stb && !busy && os_q == OS_DATA) begin
      col_addr <= col_addr + 1'b1;
    end
  end

  logic [9:0] pulses;
  assign pulses = {din_wr, go_reset, go_ecc, go_status, go_id, go_erase,
                   go_cbprog, go_prog, go_cbread, go_read};

  // R1: nothing is started in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pulses == '0);
  // R8: a busy cycle starts no array work and accepts no data
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> !(go_read || go_cbread || go_prog || go_cbprog ||
                      go_erase || go_id || go_ecc || din_wr));
  // R7: write protect blocks program and erase starts
  a_r7_wp_guard: assert property (@(posedge clk) disable iff (rst)
    $past(!wp_n) |-> !(go_prog || go_cbprog || go_erase));
  // R10: read strobes in status mode hold the column
  a_r10_status_hold: assert property (@(posedge clk) disable iff (rst)
    $past(os_q == OS_STATUS && rd_stb && !wr_stb) |-> col_addr == $past(col_addr));
  // R4: a data byte write moves the column one past the written byte
  a_r4_din_advance: assert property (@(posedge clk) disable iff (rst)
    din_wr |-> col_addr == COL_W'(din_col + 1'b1));
  // R13: at most one start pulse per cycle
  a_r13_single_pulse: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulses));
endmodule

// File: tb/nseq_front_bench.sv
module nseq_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] P_RD = 10'd1, P_CBR = 10'd2, P_PG = 10'd4, P_CBP = 10'd8,
    P_ER = 10'd16, P_ID = 10'd32, P_ST = 10'd64, P_ECC = 10'd128, P_RST = 10'd256,
    P_DIN = 10'd512;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_stb = 1'b0, rd_stb = 1'b0, cle = 1'b0, ale = 1'b0, wp_n = 1'b1, busy = 1'b0;
  logic [7:0] io = 8'h00;
  logic go_read, go_cbread, go_prog, go_cbprog, go_erase, go_id, go_status, go_ecc, go_reset;
  logic din_wr;
  logic [11:0] din_col, col_addr;
  logic [7:0] din_byte;
  logic [15:0] row_addr;
  logic [1:0] out_sel;

  int checks = 0, fails = 0;
  logic [37:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nseq_front u_nseq_front (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .cle(cle), .ale(ale),
    .io_in(io), .wp_n(wp_n), .busy(busy), .go_read(go_read), .go_cbread(go_cbread),
    .go_prog(go_prog), .go_cbprog(go_cbprog), .go_erase(go_erase), .go_id(go_id),
    .go_status(go_status), .go_ecc(go_ecc), .go_reset(go_reset), .din_wr(din_wr),
    .din_col(din_col), .din_byte(din_byte), .col_addr(col_addr), .row_addr(row_addr),
    .out_sel(out_sel)
  );

  function automatic logic [37:0] ev(input logic [9:0] p, input logic [11:0] c,
                                     input logic [15:0] r);
    return {p, c, r};
  endfunction

  task automatic expect_ev(input string tag, input logic [9:0] p, input logic [11:0] c,
                           input logic [15:0] r);
    exp_q.push_back(ev(p, c, r));
    tag_q.push_back(tag);
  endtask

  // monitor: compare every pulse the design raises with the scoreboard
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      logic [9:0] p;
      logic [37:0] got;
      p = {din_wr, go_reset, go_ecc, go_status, go_id, go_erase, go_cbprog, go_prog,
           go_cbread, go_read};
      if (p != '0) begin
        got = din_wr ? ev(p, din_col, {8'h00, din_byte}) : ev(p, col_addr, row_addr);
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL unexpected pulse: actual %h expected none (R7/R8/R9)", got);
        end else begin
          logic [37:0] want;
          string t;
          want = exp_q.pop_front();
          t = tag_q.pop_front();
          if (got !== want) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", t, got, want);
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk);
    cle = c; ale = a; io = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d); wcyc(1'b1, 1'b0, d); endtask
  task automatic adr(input logic [7:0] d); wcyc(1'b0, 1'b1, d); endtask
  task automatic dat(input logic [7:0] d); wcyc(1'b0, 1'b0, d); endtask

  task automatic rdp();
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic addr4(input logic [11:0] c, input logic [15:0] r);
    adr(c[7:0]); adr({4'h0, c[11:8]}); adr(r[7:0]); adr(r[15:8]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 out_sel", {14'h0, out_sel}, 16'h0);
    chk("R1 col", {4'h0, col_addr}, 16'h0);
    chk("R1 row", row_addr, 16'h0);
    // R1/R2: read with no leading 00h; upper nibble of byte 2 ignored
    expect_ev("R2 read", P_RD, 12'h123, 16'hA5C3);
    adr(8'h23); adr(8'hF1); adr(8'hC3); adr(8'hA5); cmd(8'h30);
    chk("R2 col", {4'h0, col_addr}, 16'h0123);
    // R10: read strobes advance the column in data mode
    rdp(); rdp(); rdp();
    chk("R10 data advance", {4'h0, col_addr}, 16'h0126);
    // R11: status then back to data at the same column
    expect_ev("R11 status", P_ST, 12'h126, 16'hA5C3);
    cmd(8'h70);
    chk("R11 status sel", {14'h0, out_sel}, 16'h1);
    rdp(); rdp();
    chk("R10 status hold", {4'h0, col_addr}, 16'h0126);
    cmd(8'h00);
    chk("R11 back to data", {14'h0, out_sel}, 16'h0);
    chk("R11 col kept", {4'h0, col_addr}, 16'h0126);
    rdp();
    chk("R11 resume", {4'h0, col_addr}, 16'h0127);
    // R3: fifth address byte ignored
    expect_ev("R3 read", P_RD, 12'h7FF, 16'h0041);
    cmd(8'h00); addr4(12'h7FF, 16'h0041); adr(8'hEE); cmd(8'h30);
    // R12: column change during output
    cmd(8'h05); adr(8'h10); adr(8'h02); cmd(8'hE0);
    chk("R12 col change", {4'h0, col_addr}, 16'h0210);
    // R4/R5/R14: program with column change and a foreign opcode
    expect_ev("R4 din0", P_DIN, 12'h005, 16'h00AA);
    expect_ev("R4 din1", P_DIN, 12'h006, 16'h00BB);
    expect_ev("R5 din", P_DIN, 12'h040, 16'h00CC);
    expect_ev("R14 prog", P_PG, 12'h041, 16'h0100);
    cmd(8'h80); addr4(12'h005, 16'h0100); dat(8'hAA); dat(8'hBB);
    cmd(8'h85); adr(8'h40); adr(8'h00);
    chk("R5 col moved", {4'h0, col_addr}, 16'h0040);
    dat(8'hCC); cmd(8'h42); cmd(8'h10);
    // R7: write protect
    wp_n = 1'b0;
    expect_ev("R7 din", P_DIN, 12'h300, 16'h0001);
    cmd(8'h80); addr4(12'h300, 16'h0700); dat(8'h01); cmd(8'h10);
    cmd(8'h60); adr(8'h11); adr(8'h22); cmd(8'hD0);
    chk("R7 row kept", row_addr, 16'h0700);
    wp_n = 1'b1;
    // R6: erase
    expect_ev("R6 erase", P_ER, 12'h301, 16'h0380);
    cmd(8'h60); adr(8'h80); adr(8'h03); cmd(8'hD0);
    // R9/R13: ID read aborts an open program
    expect_ev("R9 din", P_DIN, 12'h020, 16'h0011);
    expect_ev("R13 id", P_ID, 12'h021, 16'h0200);
    cmd(8'h80); addr4(12'h020, 16'h0200); dat(8'h11); cmd(8'h90); adr(8'h00);
    chk("R13 id sel", {14'h0, out_sel}, 16'h2);
    cmd(8'h10);
    // R8: busy restrictions
    cmd(8'h00);
    busy = 1'b1;
    rdp();
    chk("R8 busy rd", {4'h0, col_addr}, 16'h0021);
    cmd(8'h60); adr(8'h01); adr(8'h02); cmd(8'hD0); cmd(8'h90);
    expect_ev("R8 status", P_ST, 12'h021, 16'h0200);
    cmd(8'h70);
    expect_ev("R13 reset", P_RST, 12'h021, 16'h0200);
    cmd(8'hFF);
    busy = 1'b0;
    chk("R13 reset sel", {14'h0, out_sel}, 16'h0);
    // R13: ECC status
    expect_ev("R13 ecc", P_ECC, 12'h021, 16'h0200);
    cmd(8'h7A);
    chk("R13 ecc sel", {14'h0, out_sel}, 16'h3);
    // R12: copy-back read and program
    expect_ev("R12 cbread", P_CBR, 12'h000, 16'h0500);
    expect_ev("R12 cb din", P_DIN, 12'h010, 16'h005A);
    expect_ev("R12 cbprog", P_CBP, 12'h011, 16'h0600);
    cmd(8'h00); addr4(12'h000, 16'h0500); cmd(8'h35);
    cmd(8'h85); addr4(12'h010, 16'h0600); dat(8'h5A); cmd(8'h10);
    repeat (3) @(negedge clk);
    chk("R12 queue drained", 16'(exp_q.size()), 16'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule